// File: doc/BRIEF.md
# Event-Latching Status Register Group

This block forms one level of a layered status-reporting tree. It watches a vector of condition levels, one per bit position. A transition filter on each bit decides which edges of that condition count as events. An event that passes its filter is latched into a sticky event register. The bit stays there until software reads the register, and that read clears it.

A per-bit enable mask selects which latched events reach a single summary output. The summary is the OR over all positions of event AND enable. It is driven continuously and is meant to be wired into one condition input of the next higher group of the same kind.

Software reaches the block through a plain register port: a 2-bit address, a write strobe with data, a read strobe, and combinational read data. Address 0 is the event register. Address 1 is the enable mask. Address 2 holds the rising-edge filter. Address 3 holds the falling-edge filter.

Top module: `stat_evt_group`

## Requirements
- R1: A condition bit that holds a constant level, high or low, never sets its event bit, however long it stays there.
- R2: A 0-to-1 change of a condition bit sets its event bit one clock later only if that bit's rising filter (address 2) is 1. With the filter at 0, the rise is dropped.
- R3: A 1-to-0 change of a condition bit sets its event bit one clock later only if that bit's falling filter (address 3) is 1. With the filter at 0, the fall is dropped.
- R4: With rdEn high and address 0, rdData shows the event contents in that cycle, and the register is zero after that clock edge. A write to address 0 has no effect.
- R5: A set event bit stays set for any number of cycles until address 0 is read.
- R6: summaryOut equals the OR over all bits of (event AND enable). An enable bit of 0 keeps its event out of the summary. A change to the mask shows on summaryOut right after the writing edge.
- R7: The enable mask and both filter registers read back what was last written, and a read leaves them unchanged.
- R8: A filtered transition arriving in the same cycle as a clearing read of address 0 is kept: its event bit is set after that read.
- R9: After reset the event register and the enable mask are zero, the rising filter is all ones, the falling filter is zero, and summaryOut is 0. The condition level present when reset is released does not count as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| condIn | input | WIDTH | Condition levels, one per bit |
| regAddr | input | 2 | Register select: 0 event, 1 enable, 2 rising filter, 3 falling filter |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | WIDTH | Write data |
| rdEn | input | 1 | Read strobe; a read of address 0 clears the event register |
| rdData | output | WIDTH | Contents of the selected register, combinational |
| summaryOut | output | 1 | OR of event AND enable over all bits |

## Verification
The event register is the block's only hidden memory that matters, and it leaks to the ports two ways. It shows at once through summaryOut whenever the mask is set. It also shows on the next read of address 0. So a bit that is lost, spurious or stuck appears either in the same cycle on the summary or at the first event read. A wrong filter or mask register appears on its own read-back. A clear that fires too often or too rarely shows as a second event read that is not zero, or as a missing bit after a read that coincided with a transition.

// File: rtl/stat_evt_pkg.sv
package stat_evt_pkg;

  localparam int AddrW = 2;

  localparam logic [AddrW-1:0] AddrEvent  = 2'd0;
  localparam logic [AddrW-1:0] AddrEnable = 2'd1;
  localparam logic [AddrW-1:0] AddrRiseF  = 2'd2;
  localparam logic [AddrW-1:0] AddrFallF  = 2'd3;

  typedef struct packed {
    logic evtClr;
    logic enWr;
    logic riseWr;
    logic fallWr;
  } strobe_t;

endpackage

// File: rtl/stat_evt_ctrl.sv
module stat_evt_ctrl
  import stat_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AddrW-1:0] regAddr,
  input  logic             wrEn,
  input  logic             rdEn,
  output strobe_t          strobes
);

  always_comb begin
    strobes        = '0;
    strobes.evtClr = rdEn && (regAddr == AddrEvent);
    strobes.enWr   = wrEn && (regAddr == AddrEnable);
    strobes.riseWr = wrEn && (regAddr == AddrRiseF);
    strobes.fallWr = wrEn && (regAddr == AddrFallF);
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobes.enWr, strobes.riseWr, strobes.fallWr}) <= 1); // R7

  AST_CLR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.evtClr |-> rdEn); // R4

endmodule

// File: rtl/stat_evt_dpath.sv
module stat_evt_dpath
  import stat_evt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] condIn,
  input  strobe_t          strobes,
  input  logic [AddrW-1:0] regAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             summaryOut
);

  localparam logic [WIDTH-1:0] RiseRst = '1;
  localparam logic [WIDTH-1:0] FallRst = '0;

  logic [WIDTH-1:0] condPrev;
  logic             primed;
  logic [WIDTH-1:0] eventReg;
  logic [WIDTH-1:0] enableReg;
  logic [WIDTH-1:0] riseFilt;
  logic [WIDTH-1:0] fallFilt;
  logic [WIDTH-1:0] hit;

  // Per-bit transition filter
  for (genvar b = 0; b < WIDTH; b++) begin : g_filt
    logic rise;
    logic fall;
    assign rise   = condIn[b] & ~condPrev[b] & riseFilt[b];
    assign fall   = ~condIn[b] & condPrev[b] & fallFilt[b];
    assign hit[b] = primed & (rise | fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      condPrev <= '0;
      primed   <= 1'b0;
    end else begin
      condPrev <= condIn;
      primed   <= 1'b1;
    end
  end

  // Sticky events; a new hit wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eventReg <= '0;
    end else begin
      eventReg <= (strobes.evtClr ? '0 : eventReg) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enableReg <= '0;
      riseFilt  <= RiseRst;
      fallFilt  <= FallRst;
    end else begin
      if (strobes.enWr)   enableReg <= wrData;
      if (strobes.riseWr) riseFilt  <= wrData;
      if (strobes.fallWr) fallFilt  <= wrData;
    end
  end

  always_comb begin
    unique case (regAddr)
      AddrEvent:  rdData = eventReg;
      AddrEnable: rdData = enableReg;
      AddrRiseF:  rdData = riseFilt;
      default:    rdData = fallFilt;
    endcase
  end

  assign summaryOut = |(eventReg & enableReg);

  AST_LEVEL_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (condIn == condPrev && !strobes.evtClr) |=> eventReg == $past(eventReg)); // R1

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.evtClr |=> (eventReg & ~$past(hit)) == '0); // R4

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.evtClr |=> (eventReg & $past(eventReg)) == $past(eventReg)); // R5

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (enableReg == '0) |-> !summaryOut); // R6

  AST_ENABLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.enWr |=> $stable(enableReg)); // R7

  AST_RACE_KEEPS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.evtClr |=> (eventReg & $past(hit)) == $past(hit)); // R8

endmodule

// File: rtl/stat_evt_group.sv
module stat_evt_group
  import stat_evt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] condIn,
  input  logic [1:0]       regAddr,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             summaryOut
);

  strobe_t strobes;

  stat_evt_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (regAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  stat_evt_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .condIn     (condIn),
    .strobes    (strobes),
    .regAddr    (regAddr),
    .wrData     (wrData),
    .rdData     (rdData),
    .summaryOut (summaryOut)
  );

endmodule

// File: tb/stat_evt_group_tb.sv
module stat_evt_group_tb;

  localparam int ClkPeriod = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] condIn = '0;
  logic [1:0]   regAddr = '0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic [W-1:0] rdData;
  logic         summaryOut;

  int tests = 0;
  int fails = 0;

  always #(ClkPeriod/2) clk = ~clk;

  stat_evt_group #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .condIn(condIn), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .summaryOut(summaryOut)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All stimulus changes at negedge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setCond(input logic [W-1:0] v);
    @(negedge clk);
    condIn = v;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [W-1:0] d;
    check("R9 summary", {15'd0, summaryOut}, '0);
    readReg(2'd0, d); check("R9 event after reset", d, 16'h0000);
    readReg(2'd1, d); check("R9 enable", d, 16'h0000);
    readReg(2'd2, d); check("R9 rise filter", d, 16'hFFFF);
    readReg(2'd3, d); check("R9 fall filter", d, 16'h0000);
  endtask

  task automatic testRiseAndClear();
    logic [W-1:0] d;
    setCond(16'h00F1);
    readReg(2'd0, d); check("R2 rise sets bit0", d, 16'h0001);
    readReg(2'd0, d); check("R4 second read zero", d, 16'h0000);
    idle(5);
    readReg(2'd0, d); check("R1 held level no event", d, 16'h0000);
    setCond(16'h0000);
    readReg(2'd0, d); check("R3 fall dropped with filter 0", d, 16'h0000);
    writeReg(2'd0, 16'hFFFF);
    readReg(2'd0, d); check("R4 write to event ignored", d, 16'h0000);
  endtask

  task automatic testFallFilter();
    logic [W-1:0] d;
    writeReg(2'd3, 16'h0002);
    writeReg(2'd2, 16'hFFFD);
    setCond(16'h0002);
    readReg(2'd0, d); check("R2 rise dropped with filter 0", d, 16'h0000);
    setCond(16'h0000);
    readReg(2'd0, d); check("R3 fall sets bit1", d, 16'h0002);
    readReg(2'd3, d); check("R7 fall filter readback", d, 16'h0002);
    readReg(2'd2, d); check("R7 rise filter readback", d, 16'hFFFD);
    writeReg(2'd2, 16'hFFFF);
    writeReg(2'd3, 16'h0000);
  endtask

  task automatic testSummary();
    logic [W-1:0] d;
    setCond(16'h0004);
    check("R6 masked event no summary", {15'd0, summaryOut}, '0);
    writeReg(2'd1, 16'h0004);
    check("R6 enabled event summary", {15'd0, summaryOut}, 16'h0001);
    writeReg(2'd1, 16'h0008);
    check("R6 other mask bit no summary", {15'd0, summaryOut}, '0);
    readReg(2'd1, d); check("R7 enable readback", d, 16'h0008);
    readReg(2'd1, d); check("R7 enable read nondestructive", d, 16'h0008);
    writeReg(2'd1, 16'h0004);
    readReg(2'd0, d); check("R4 event content", d, 16'h0004);
    check("R6 summary drops after clear", {15'd0, summaryOut}, '0);
    setCond(16'h0000);
  endtask

  task automatic testSticky();
    logic [W-1:0] d;
    setCond(16'h0008);
    setCond(16'h0000);
    writeReg(2'd1, 16'h00FF);
    idle(20);
    check("R5 summary while held", {15'd0, summaryOut}, 16'h0001);
    readReg(2'd0, d); check("R5 bit3 still set", d, 16'h0008);
  endtask

  task automatic testRace();
    logic [W-1:0] d;
    setCond(16'h0020);
    @(negedge clk);
    regAddr = 2'd0; rdEn = 1'b1; condIn = 16'h0030;
    #1 d = rdData;
    check("R8 read shows old content", d, 16'h0020);
    @(negedge clk);
    rdEn = 1'b0;
    readReg(2'd0, d); check("R8 same-cycle event kept", d, 16'h0010);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    condIn = 16'h00F0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    testReset();
    testRiseAndClear();
    testFallFilter();
    testSummary();
    testSticky();
    testRace();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule